// File: doc/BRIEF.md
# Mode-Banked General Register File

This block stores the general-purpose registers R0 to R14 and the saved status words of a processor that runs in several privileged modes. A 5-bit mode number picks a register bank. Each access then reaches the physical copy that belongs to that mode. Each port either follows the block's current mode or names a mode of its own. A port that names a mode reaches that mode's copies without any mode switch.

There are two register read ports and one register write port. A saved-status read port and a saved-status write port are keyed by mode in the same way. The current mode is held in a register and is replaced on the clock edge after a load request. Because each port decodes its bank combinationally, a mode change never spends cycles copying registers between banks. R15 is not held here. An index of 15 on any port raises an error flag and never reaches storage.

Top module: `bank_rf`

## Requirements
- R1: Mode codes map to banks as follows. Codes 0 and 16 map to user, 1 and 17 to fast-interrupt, 2 and 18 to interrupt, 3 and 19 to supervisor, 23 to abort and 27 to undefined. Code 31 (system) uses the user bank. Every other code maps to a dummy bank.
- R2: R0 to R7 are a single set shared by every mode, the dummy bank included.
- R3: The fast-interrupt bank has private R8 to R14. Writes made there never alter the user copies of R8 to R12, and writes to the user copies never alter the fast-interrupt copies.
- R4: The interrupt, supervisor, abort and undefined banks each have private R13 and R14, and share R8 to R12 with the user bank.
- R5: In the dummy bank, R8 to R14 read as zero and writes to them are dropped.
- R6: When a port's use-current input is 1, the port takes the current mode; otherwise it takes its own mode input. A load request replaces the current mode on the next clock edge. The current mode is output as `curMode`.
- R7: When the write port and a read port reach the same physical register in the same cycle, the read returns the write data (write-first).
- R8: A saved-status read for a bank without a saved-status word (user, system or dummy) returns `cpsrIn`. A saved-status write to such a bank is dropped.
- R9: A saved-status write changes byte lane k (bits 8k+7 to 8k) only when mask bit k is 1. Bit 0 selects the control byte, bit 1 the extension byte, bit 2 the status byte and bit 3 the flags byte.
- R10: An index of 15 on either read port, or on the write port while it is enabled, drives `idxErr` high in the same cycle. A read at index 15 returns zero. A write at index 15 is dropped.
- R11: After reset, every register and every saved-status word is zero and the current mode is 19.
- R12: A saved-status read of the same bank as a saved-status write in the same cycle returns the lane-merged value that the write produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Load `modeNext` as the current mode |
| modeNext | input | 5 | Mode to load |
| curMode | output | 5 | Current mode |
| rdAIdx | input | 4 | Read port A register index |
| rdAMode | input | 5 | Read port A named mode |
| rdAUseCur | input | 1 | Read port A follows the current mode |
| rdAData | output | 32 | Read port A data |
| rdBIdx | input | 4 | Read port B register index |
| rdBMode | input | 5 | Read port B named mode |
| rdBUseCur | input | 1 | Read port B follows the current mode |
| rdBData | output | 32 | Read port B data |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Write register index |
| wrMode | input | 5 | Write named mode |
| wrUseCur | input | 1 | Write follows the current mode |
| wrData | input | 32 | Write data |
| cpsrIn | input | 32 | Current status word, used for fallback reads |
| spsrRdMode | input | 5 | Saved-status read named mode |
| spsrRdUseCur | input | 1 | Saved-status read follows the current mode |
| spsrRdData | output | 32 | Saved-status read data |
| spsrWrEn | input | 1 | Saved-status write enable |
| spsrWrMode | input | 5 | Saved-status write named mode |
| spsrWrUseCur | input | 1 | Saved-status write follows the current mode |
| spsrWrMask | input | 4 | Byte-lane write mask |
| spsrWrData | input | 32 | Saved-status write data |
| idxErr | output | 1 | An index of 15 was presented |

## Verification
Two events can fall in the same cycle. A register write can coincide with a read that reaches the same physical copy. A mode load can coincide with accesses that follow the current mode. The bench provokes the first in two ways: it writes one shared low register under one mode and reads it under another, and it writes and reads the same banked register. It provokes the second by issuing a load while ports follow the current mode. A behavioural model applies each write before it predicts that cycle's reads, which sets the write-first expectation. The model changes mode only after its comparison, so reads in the load cycle must still see the old bank.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;
  localparam int MODE_W     = 5;
  localparam int IDX_W      = 4;
  localparam int SLOT_W     = 5;
  localparam int LOW_CNT    = 8;  // R0..R7, shared by all modes
  localparam int HI_CNT     = 5;  // R8..R12, two copies
  localparam int PRIV_BANKS = 6;  // banks owning an R13/R14 pair
  localparam int NUM_SLOTS  = LOW_CNT + 2 * HI_CNT + 2 * PRIV_BANKS;
  localparam int SPSR_CNT   = 5;
  localparam int SPSR_SEL_W = $clog2(SPSR_CNT);
  localparam logic [SLOT_W-1:0] SLOT_NONE = '1;
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_DUM
  } bank_e;

  typedef struct packed {
    logic [SLOT_W-1:0]     rdASlot;
    logic [SLOT_W-1:0]     rdBSlot;
    logic [SLOT_W-1:0]     wrSlot;
    logic                  wrEn;
    logic [SPSR_SEL_W-1:0] spRdSel;
    logic                  spRdHit;
    logic [SPSR_SEL_W-1:0] spWrSel;
    logic                  spWrEn;
  } rf_strobe_t;

  function automatic bank_e modeToBank(logic [MODE_W-1:0] m);
    case (m)
      5'd0, 5'd16, 5'd31: return BK_USR;
      5'd1, 5'd17:        return BK_FIQ;
      5'd2, 5'd18:        return BK_IRQ;
      5'd3, 5'd19:        return BK_SVC;
      5'd23:              return BK_ABT;
      5'd27:              return BK_UND;
      default:            return BK_DUM;
    endcase
  endfunction

  // Physical slot layout: 0..7 low set, 8..12 user high, 13..17 fast high,
  // 18.. R13/R14 pairs ordered by bank number.
  function automatic logic [SLOT_W-1:0] slotOf(bank_e b, logic [IDX_W-1:0] idx);
    int n;
    n = int'(idx);
    if (n == 15) return SLOT_NONE;
    if (n < LOW_CNT) return SLOT_W'(n);
    if (b == BK_DUM) return SLOT_NONE;
    if (n < LOW_CNT + HI_CNT)
      return (b == BK_FIQ) ? SLOT_W'(n + HI_CNT) : SLOT_W'(n);
    return SLOT_W'(LOW_CNT + 2 * HI_CNT + 2 * int'(b) + n - 13);
  endfunction

  function automatic logic hasSpsr(bank_e b);
    return (b != BK_USR) && (b != BK_DUM);
  endfunction

  function automatic logic [SPSR_SEL_W-1:0] spsrSel(bank_e b);
    return hasSpsr(b) ? SPSR_SEL_W'(int'(b) - 1) : '0;
  endfunction
endpackage

// File: rtl/bank_rf_ctrl.sv
module bank_rf_ctrl
  import bank_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeNext,
  output logic [MODE_W-1:0] curMode,
  input  logic [IDX_W-1:0]  rdAIdx,
  input  logic [MODE_W-1:0] rdAMode,
  input  logic              rdAUseCur,
  input  logic [IDX_W-1:0]  rdBIdx,
  input  logic [MODE_W-1:0] rdBMode,
  input  logic              rdBUseCur,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [MODE_W-1:0] wrMode,
  input  logic              wrUseCur,
  input  logic [MODE_W-1:0] spsrRdMode,
  input  logic              spsrRdUseCur,
  input  logic              spsrWrEn,
  input  logic [MODE_W-1:0] spsrWrMode,
  input  logic              spsrWrUseCur,
  output rf_strobe_t        st,
  output logic              idxErr
);
  localparam logic [IDX_W-1:0] IDX_BAD = '1;

  bank_e bankA, bankB, bankW, bankSR, bankSW;

  always_ff @(posedge clk) begin
    if (!rst_n)        curMode <= RESET_MODE;
    else if (modeLoad) curMode <= modeNext;
  end

  always_comb begin
    bankA  = modeToBank(rdAUseCur    ? curMode : rdAMode);
    bankB  = modeToBank(rdBUseCur    ? curMode : rdBMode);
    bankW  = modeToBank(wrUseCur     ? curMode : wrMode);
    bankSR = modeToBank(spsrRdUseCur ? curMode : spsrRdMode);
    bankSW = modeToBank(spsrWrUseCur ? curMode : spsrWrMode);

    st.rdASlot = slotOf(bankA, rdAIdx);
    st.rdBSlot = slotOf(bankB, rdBIdx);
    st.wrSlot  = slotOf(bankW, wrIdx);
    st.wrEn    = wrEn && (st.wrSlot != SLOT_NONE);
    st.spRdSel = spsrSel(bankSR);
    st.spRdHit = hasSpsr(bankSR);
    st.spWrSel = spsrSel(bankSW);
    st.spWrEn  = spsrWrEn && hasSpsr(bankSW);

    idxErr = (rdAIdx == IDX_BAD) || (rdBIdx == IDX_BAD) ||
             (wrEn && (wrIdx == IDX_BAD));
  end
endmodule

// File: rtl/bank_rf_dp.sv
module bank_rf_dp
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rf_strobe_t          st,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   cpsrIn,
  input  logic [DATA_W/8-1:0] spsrWrMask,
  input  logic [DATA_W-1:0]   spsrWrData,
  output logic [DATA_W-1:0]   rdAData,
  output logic [DATA_W-1:0]   rdBData,
  output logic [DATA_W-1:0]   spsrRdData
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] regs [NUM_SLOTS];
  logic [DATA_W-1:0] spsr [SPSR_CNT];
  logic [DATA_W-1:0] spsrMerged;

  function automatic logic [DATA_W-1:0] laneMerge(logic [DATA_W-1:0] oldV,
                                                  logic [DATA_W-1:0] newV,
                                                  logic [LANES-1:0] mask);
    logic [DATA_W-1:0] r;
    r = oldV;
    for (int i = 0; i < LANES; i++)
      if (mask[i]) r[i*8 +: 8] = newV[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] readSlot(logic [SLOT_W-1:0] s);
    if (s == SLOT_NONE || int'(s) >= NUM_SLOTS) return '0;
    if (st.wrEn && st.wrSlot == s) return wrData;
    return regs[s];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) regs[i] <= '0;
    end else if (st.wrEn && int'(st.wrSlot) < NUM_SLOTS) begin
      regs[st.wrSlot] <= wrData;
    end
  end

  assign spsrMerged = laneMerge(spsr[st.spWrSel], spsrWrData, spsrWrMask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPSR_CNT; i++) spsr[i] <= '0;
    end else if (st.spWrEn) begin
      spsr[st.spWrSel] <= spsrMerged;
    end
  end

  always_comb begin
    rdAData = readSlot(st.rdASlot);
    rdBData = readSlot(st.rdBSlot);
    if (!st.spRdHit)
      spsrRdData = cpsrIn;
    else if (st.spWrEn && st.spWrSel == st.spRdSel)
      spsrRdData = spsrMerged;
    else
      spsrRdData = spsr[st.spRdSel];
  end
endmodule

// File: rtl/bank_rf.sv
module bank_rf
  import bank_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                modeLoad,
  input  logic [MODE_W-1:0]   modeNext,
  output logic [MODE_W-1:0]   curMode,
  input  logic [IDX_W-1:0]    rdAIdx,
  input  logic [MODE_W-1:0]   rdAMode,
  input  logic                rdAUseCur,
  output logic [DATA_W-1:0]   rdAData,
  input  logic [IDX_W-1:0]    rdBIdx,
  input  logic [MODE_W-1:0]   rdBMode,
  input  logic                rdBUseCur,
  output logic [DATA_W-1:0]   rdBData,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [MODE_W-1:0]   wrMode,
  input  logic                wrUseCur,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   cpsrIn,
  input  logic [MODE_W-1:0]   spsrRdMode,
  input  logic                spsrRdUseCur,
  output logic [DATA_W-1:0]   spsrRdData,
  input  logic                spsrWrEn,
  input  logic [MODE_W-1:0]   spsrWrMode,
  input  logic                spsrWrUseCur,
  input  logic [DATA_W/8-1:0] spsrWrMask,
  input  logic [DATA_W-1:0]   spsrWrData,
  output logic                idxErr
);
  rf_strobe_t st;

  bank_rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeLoad(modeLoad), .modeNext(modeNext),
    .curMode(curMode),
    .rdAIdx(rdAIdx), .rdAMode(rdAMode), .rdAUseCur(rdAUseCur),
    .rdBIdx(rdBIdx), .rdBMode(rdBMode), .rdBUseCur(rdBUseCur),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrMode(wrMode), .wrUseCur(wrUseCur),
    .spsrRdMode(spsrRdMode), .spsrRdUseCur(spsrRdUseCur),
    .spsrWrEn(spsrWrEn), .spsrWrMode(spsrWrMode), .spsrWrUseCur(spsrWrUseCur),
    .st(st), .idxErr(idxErr)
  );

  bank_rf_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData), .cpsrIn(cpsrIn),
    .spsrWrMask(spsrWrMask), .spsrWrData(spsrWrData),
    .rdAData(rdAData), .rdBData(rdBData), .spsrRdData(spsrRdData)
  );
endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeLoad,
  input logic [4:0]        modeNext,
  input logic [4:0]        curMode,
  input logic [3:0]        rdAIdx,
  input logic [4:0]        rdAMode,
  input logic              rdAUseCur,
  input logic [DATA_W-1:0] rdAData,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] cpsrIn,
  input logic [4:0]        spsrRdMode,
  input logic              spsrRdUseCur,
  input logic [DATA_W-1:0] spsrRdData,
  input logic              idxErr
);
  function automatic logic isDummy(logic [4:0] m);
    return !(m inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19,
                       5'd23, 5'd27, 5'd31});
  endfunction

  logic [4:0] effA;
  assign effA = rdAUseCur ? curMode : rdAMode;

  a_r10_idx15_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAIdx == 4'd15) |-> (idxErr && rdAData == '0));

  a_r6_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    modeLoad |=> (curMode == $past(modeNext)));

  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !modeLoad |=> $stable(curMode));

  a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (isDummy(effA) && rdAIdx >= 4'd8 && rdAIdx <= 4'd14) |-> (rdAData == '0));

  a_r8_spsr_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (!spsrRdUseCur && spsrRdMode inside {5'd0, 5'd16, 5'd31})
      |-> (spsrRdData == cpsrIn));

  a_r7_low_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrIdx == rdAIdx && wrIdx < 4'd8) |-> (rdAData == wrData));
endmodule

bind bank_rf bank_rf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bank_rf_tb.sv
module bank_rf_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        modeLoad;
  logic [4:0]  modeNext, curMode;
  logic [3:0]  rdAIdx, rdBIdx, wrIdx;
  logic [4:0]  rdAMode, rdBMode, wrMode, spsrRdMode, spsrWrMode;
  logic        rdAUseCur, rdBUseCur, wrEn, wrUseCur;
  logic        spsrRdUseCur, spsrWrEn, spsrWrUseCur;
  logic [31:0] rdAData, rdBData, wrData, cpsrIn, spsrRdData, spsrWrData;
  logic [3:0]  spsrWrMask;
  logic        idxErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model: one full register image per bank (0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,6 dummy)
  logic [31:0] mR [7][16];
  logic [31:0] mS [7];
  logic [4:0]  mCur;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_rf u_dut (
    .clk(clk), .rst_n(rst_n), .modeLoad(modeLoad), .modeNext(modeNext),
    .curMode(curMode),
    .rdAIdx(rdAIdx), .rdAMode(rdAMode), .rdAUseCur(rdAUseCur), .rdAData(rdAData),
    .rdBIdx(rdBIdx), .rdBMode(rdBMode), .rdBUseCur(rdBUseCur), .rdBData(rdBData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrMode(wrMode), .wrUseCur(wrUseCur),
    .wrData(wrData), .cpsrIn(cpsrIn),
    .spsrRdMode(spsrRdMode), .spsrRdUseCur(spsrRdUseCur), .spsrRdData(spsrRdData),
    .spsrWrEn(spsrWrEn), .spsrWrMode(spsrWrMode), .spsrWrUseCur(spsrWrUseCur),
    .spsrWrMask(spsrWrMask), .spsrWrData(spsrWrData), .idxErr(idxErr)
  );

  function automatic int bankOf(logic [4:0] m);
    case (m)
      5'd0, 5'd16, 5'd31: return 0;
      5'd1, 5'd17:        return 1;
      5'd2, 5'd18:        return 2;
      5'd3, 5'd19:        return 3;
      5'd23:              return 4;
      5'd27:              return 5;
      default:            return 6;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(logic [4:0] m, logic [3:0] idx);
    int b = bankOf(m);
    if (idx == 4'd15) return 32'h0;
    if (b == 6 && idx >= 4'd8) return 32'h0;
    return mR[b][idx];
  endfunction

  task automatic modelWrite(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    int b = bankOf(m);
    if (idx == 4'd15) return;
    if (idx < 4'd8) begin
      for (int k = 0; k < 7; k++) mR[k][idx] = d;
    end else if (b == 6) begin
      return;
    end else if (idx < 4'd13) begin
      if (b == 1) mR[1][idx] = d;
      else for (int k = 0; k < 6; k++) if (k != 1) mR[k][idx] = d;
    end else begin
      mR[b][idx] = d;
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic clearIns();
    modeLoad = 0; modeNext = 0;
    rdAIdx = 0; rdAMode = 0; rdAUseCur = 0;
    rdBIdx = 0; rdBMode = 0; rdBUseCur = 0;
    wrEn = 0; wrIdx = 0; wrMode = 0; wrUseCur = 0; wrData = 0;
    spsrRdMode = 0; spsrRdUseCur = 0;
    spsrWrEn = 0; spsrWrMode = 0; spsrWrUseCur = 0; spsrWrMask = 0; spsrWrData = 0;
  endtask

  // Inputs are set just after a falling edge; compare, then clock.
  task automatic cyc(string tag);
    logic [4:0] eA, eB, eW, eSR, eSW;
    logic [31:0] expA, expB, expS;
    logic expErr;
    int bw, br;
    eA  = rdAUseCur    ? mCur : rdAMode;
    eB  = rdBUseCur    ? mCur : rdBMode;
    eW  = wrUseCur     ? mCur : wrMode;
    eSR = spsrRdUseCur ? mCur : spsrRdMode;
    eSW = spsrWrUseCur ? mCur : spsrWrMode;
    // commit this cycle's writes first: write-first reads (R7, R12)
    if (wrEn) modelWrite(eW, wrIdx, wrData);
    bw = bankOf(eSW);
    if (spsrWrEn && bw != 0 && bw != 6)
      for (int l = 0; l < 4; l++)
        if (spsrWrMask[l]) mS[bw][l*8 +: 8] = spsrWrData[l*8 +: 8];
    expA = modelRead(eA, rdAIdx);
    expB = modelRead(eB, rdBIdx);
    br = bankOf(eSR);
    expS = (br == 0 || br == 6) ? cpsrIn : mS[br];
    expErr = (rdAIdx == 4'd15) || (rdBIdx == 4'd15) || (wrEn && wrIdx == 4'd15);
    #1;
    check(tag, "rdAData", rdAData, expA);
    check(tag, "rdBData", rdBData, expB);
    check(tag, "spsrRdData", spsrRdData, expS);
    check(tag, "idxErr", {31'h0, idxErr}, {31'h0, expErr});
    check(tag, "curMode", {27'h0, curMode}, {27'h0, mCur});
    @(posedge clk);
    if (modeLoad) mCur = modeNext;
    @(negedge clk);
  endtask

  function automatic logic [4:0] randMode();
    int r = $urandom % 13;
    case (r)
      0: return 5'd0;   1: return 5'd1;   2: return 5'd2;   3: return 5'd3;
      4: return 5'd16;  5: return 5'd17;  6: return 5'd18;  7: return 5'd19;
      8: return 5'd23;  9: return 5'd27;  10: return 5'd31;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 7; b++) begin
      mS[b] = 32'h0;
      for (int i = 0; i < 16; i++) mR[b][i] = 32'h0;
    end
    mCur = 5'd19;
    cpsrIn = 32'hF00000D3;
    clearIns();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset contents and mode
    clearIns(); rdAIdx = 4'd0; rdBIdx = 4'd13; rdBUseCur = 1; spsrRdMode = 5'd17;
    cyc("R11");

    // R2: low registers are shared across modes
    clearIns(); wrEn = 1; wrIdx = 4'd3; wrMode = 5'd16; wrData = 32'hA0A0_0003;
    rdAIdx = 4'd3; rdAMode = 5'd17;
    cyc("R2");
    clearIns(); rdAIdx = 4'd3; rdAMode = 5'd23; rdBIdx = 4'd3; rdBMode = 5'd9;
    cyc("R2");

    // R3: fast bank high registers are private
    clearIns(); wrEn = 1; wrIdx = 4'd9; wrMode = 5'd17; wrData = 32'hB0B0_0009;
    cyc("R3");
    clearIns(); wrEn = 1; wrIdx = 4'd9; wrMode = 5'd0; wrData = 32'hC0C0_0009;
    cyc("R3");
    clearIns(); rdAIdx = 4'd9; rdAMode = 5'd17; rdBIdx = 4'd9; rdBMode = 5'd19;
    cyc("R3");

    // R6: mode load takes effect on the next edge
    clearIns(); modeLoad = 1; modeNext = 5'd17; rdAIdx = 4'd9; rdAUseCur = 1;
    cyc("R6");
    clearIns(); modeLoad = 1; modeNext = 5'd16; rdAIdx = 4'd9; rdAUseCur = 1;
    cyc("R6");
    clearIns(); rdAIdx = 4'd9; rdAUseCur = 1; wrEn = 1; wrUseCur = 1;
    wrIdx = 4'd12; wrData = 32'h1212_0012;
    cyc("R6");

    // R4: other privileged banks: private R13/R14, shared R8..R12
    clearIns(); wrEn = 1; wrIdx = 4'd13; wrMode = 5'd18; wrData = 32'hD0D0_0013;
    rdAIdx = 4'd13; rdAMode = 5'd19;
    cyc("R4");
    clearIns(); rdAIdx = 4'd13; rdAMode = 5'd18; rdBIdx = 4'd9; rdBMode = 5'd27;
    cyc("R4");
    clearIns(); rdAIdx = 4'd12; rdAMode = 5'd23; rdBIdx = 4'd13; rdBMode = 5'd31;
    cyc("R4");

    // R5: dummy bank high registers read zero, writes dropped
    clearIns(); wrEn = 1; wrIdx = 4'd10; wrMode = 5'd5; wrData = 32'hE0E0_0010;
    rdAIdx = 4'd10; rdAMode = 5'd5;
    cyc("R5");
    clearIns(); rdAIdx = 4'd10; rdAMode = 5'd0; rdBIdx = 4'd14; rdBMode = 5'd30;
    cyc("R5");

    // R7: write-first on a banked register
    clearIns(); wrEn = 1; wrIdx = 4'd14; wrMode = 5'd23; wrData = 32'hF0F0_0014;
    rdAIdx = 4'd14; rdAMode = 5'd23; rdBIdx = 4'd14; rdBMode = 5'd27;
    cyc("R7");

    // R8: no saved-status word in user/system/dummy
    clearIns(); spsrWrEn = 1; spsrWrMode = 5'd16; spsrWrMask = 4'hF;
    spsrWrData = 32'h5555_5555; spsrRdMode = 5'd16;
    cyc("R8");
    clearIns(); spsrRdMode = 5'd18;
    cyc("R8");
    clearIns(); spsrRdMode = 5'd12; cpsrIn = 32'h6000_0010;
    cyc("R8");

    // R9: byte-lane masking
    clearIns(); spsrWrEn = 1; spsrWrMode = 5'd18; spsrWrMask = 4'b0101;
    spsrWrData = 32'h1122_3344;
    cyc("R9");
    clearIns(); spsrWrEn = 1; spsrWrMode = 5'd18; spsrWrMask = 4'b1000;
    spsrWrData = 32'hAABB_CCDD;
    cyc("R9");
    clearIns(); spsrRdMode = 5'd18;
    cyc("R9");

    // R12: saved-status write-first
    clearIns(); spsrWrEn = 1; spsrWrMode = 5'd1; spsrWrMask = 4'b0011;
    spsrWrData = 32'h9988_7766; spsrRdMode = 5'd17;
    cyc("R12");

    // R10: index 15
    clearIns(); rdAIdx = 4'd15; rdAMode = 5'd19; wrEn = 1; wrIdx = 4'd15;
    wrData = 32'hDEAD_BEEF;
    cyc("R10");
    clearIns(); rdBIdx = 4'd15; rdBMode = 5'd17;
    cyc("R10");
    clearIns(); wrEn = 0; wrIdx = 4'd15;
    cyc("R10");

    // R1: random traffic over every mode code
    for (int n = 0; n < 4000; n++) begin
      modeLoad = ($urandom % 8) == 0; modeNext = randMode();
      rdAIdx = 4'($urandom); rdAMode = randMode(); rdAUseCur = $urandom % 2;
      rdBIdx = 4'($urandom); rdBMode = randMode(); rdBUseCur = $urandom % 2;
      wrEn = $urandom % 2; wrIdx = 4'($urandom); wrMode = randMode();
      wrUseCur = $urandom % 2; wrData = $urandom;
      cpsrIn = $urandom;
      spsrRdMode = randMode(); spsrRdUseCur = $urandom % 2;
      spsrWrEn = $urandom % 2; spsrWrMode = randMode(); spsrWrUseCur = $urandom % 2;
      spsrWrMask = 4'($urandom); spsrWrData = $urandom;
      cyc("R1");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule